// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Per-Line Forwarding

This block gathers 32 level-sensitive interrupt request lines and combines them into a single summary request. Each raw level is gated by a per-line enable mask, and the summary line is the OR of all gated bits. The summary drives output line 31, which is meant to feed the matching input of an upstream primary controller.

A second path lets software route selected inputs directly to the primary controller. This path is only available for inputs 21 through 30. When a line's forwarding bit is set, output line i follows input i. Every output line from 0 to 30 whose forwarding bit is clear stays low.

Software reaches the block through a small word-addressed slave port in a 4 KB window. Enable bits and forwarding bits each have their own set and clear registers. A dedicated pair of registers raises and lowers enable bit 0 as a software interrupt. All outputs are registered and change one clock after the input change or register write that causes them.

Top module: `sic_fwd_top`

## Requirements
- R1: Output line 31 is high exactly when some bit of (registered raw level AND enable mask) is set. It updates one clock after an input change or an enable write.
- R2: Reads return the following, by word index (byte address bits [11:2]). Index 0 gives raw AND enable, index 1 gives the raw level, and index 2 gives the enable mask.
- R3: A write at index 2 sets every enable bit written as 1. A write at index 3 clears every enable bit written as 1. Bits written as 0 keep their value.
- R4: A read at index 4 returns raw bit 0 in data bit 0, with all other bits zero. A nonzero write at index 4 sets enable bit 0, and a nonzero write at index 5 clears it. A write of zero at index 4 or 5 changes nothing.
- R5: A read at index 8 returns the forwarding enables. A write at index 8 sets only the written-1 bits that fall in positions 21..30 (mask 0x7FE00000). A write at index 9 clears every bit written as 1.
- R6: For i in 21..30, output line i equals forwarding bit i AND input i, one clock after either changes. Lines 0..20 are always low, and so is any line in 21..30 whose forwarding bit is clear.
- R7: Reads at unmapped indices (6, 7 and 10 and above) return zero. Writes at any of them change neither the enable mask nor the forwarding enables.
- R8: After reset the enable mask, the forwarding enables, all outputs and the read data are zero.
- R9: Read data is valid in the cycle after the read strobe. In any cycle that does not follow a read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| bus_word | input | 10 | Register word index (byte address bits [11:2]) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_out | output | 32 | Lines 21..30 forwarded, line 31 summary |

## Verification
The hardest state to reach is a forwarding line whose enable changes while its input is already high. The output must then rise or fall on the write alone, with no edge on the input. Reaching this needs an input held high across a forwarding set write, followed by a clear write. The stimulus holds random input patterns steady across random writes at every register index, including the forwarding indices. It also uses directed steps that set and clear forwarding on an asserted line and try to set bits outside 21..30.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int unsigned LINES = 32;
    localparam int unsigned IDX_W = 10;

    typedef logic [LINES-1:0] vec_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_MASKED   = 10'd0,
        IDX_RAW      = 10'd1,
        IDX_EN_SET   = 10'd2,
        IDX_EN_CLR   = 10'd3,
        IDX_SOFT_SET = 10'd4,
        IDX_SOFT_CLR = 10'd5,
        IDX_FWD_SET  = 10'd8,
        IDX_FWD_CLR  = 10'd9
    } reg_idx_e;

    typedef struct packed {
        vec_t en;
        vec_t fwd;
        vec_t raw;
        vec_t rdata;
    } bank_state_t;
endpackage

// File: rtl/sic_regbank.sv
module sic_regbank
    import sic_pkg::*;
#(
    parameter int unsigned FWD_LO = 21,
    parameter int unsigned FWD_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vec_t             irq_in,
    input  logic [IDX_W-1:0] word_idx,
    input  logic             wr,
    input  logic             rd,
    input  vec_t             wdata,
    output vec_t             en_next,
    output vec_t             fwd_next,
    output vec_t             en_q,
    output vec_t             fwd_q,
    output vec_t             raw_q,
    output vec_t             rdata
);
    localparam vec_t ONES     = {LINES{1'b1}};
    localparam vec_t FWD_MASK = (ONES >> (LINES - 1 - FWD_HI)) & (ONES << FWD_LO);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.raw   = irq_in;
        st_d.rdata = '0;
        if (wr) begin
            case (word_idx)
                IDX_EN_SET:   st_d.en = st_q.en | wdata;
                IDX_EN_CLR:   st_d.en = st_q.en & ~wdata;
                IDX_SOFT_SET: if (|wdata) st_d.en[0] = 1'b1;
                IDX_SOFT_CLR: if (|wdata) st_d.en[0] = 1'b0;
                IDX_FWD_SET:  st_d.fwd = st_q.fwd | (wdata & FWD_MASK);
                IDX_FWD_CLR:  st_d.fwd = st_q.fwd & ~wdata;
                default: ;
            endcase
        end
        if (rd) begin
            case (word_idx)
                IDX_MASKED:   st_d.rdata = st_q.raw & st_q.en;
                IDX_RAW:      st_d.rdata = st_q.raw;
                IDX_EN_SET:   st_d.rdata = st_q.en;
                IDX_SOFT_SET: st_d.rdata = {{(LINES-1){1'b0}}, st_q.raw[0]};
                IDX_FWD_SET:  st_d.rdata = st_q.fwd;
                default:      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_next  = st_d.en;
    assign fwd_next = st_d.fwd;
    assign en_q     = st_q.en;
    assign fwd_q    = st_q.fwd;
    assign raw_q    = st_q.raw;
    assign rdata    = st_q.rdata;

    assert_fwd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_q & ~FWD_MASK) == '0);

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0);

    assert_enset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word_idx == IDX_EN_SET) |=> (en_q & $past(wdata)) == $past(wdata));

    assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (word_idx == 10'd6 || word_idx == 10'd7 || word_idx > 10'd9))
        |=> (en_q == $past(en_q)) && (fwd_q == $past(fwd_q)));
endmodule

// File: rtl/sic_outstage.sv
module sic_outstage
    import sic_pkg::*;
#(
    parameter int unsigned FWD_LO   = 21,
    parameter int unsigned FWD_HI   = 30,
    parameter int unsigned SUM_LINE = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  vec_t irq_in,
    input  vec_t en_next,
    input  vec_t fwd_next,
    output vec_t irq_out
);
    vec_t out_d, out_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i == SUM_LINE) begin : g_sum
            assign out_d[i] = |(irq_in & en_next);
        end else if (i >= FWD_LO && i <= FWD_HI) begin : g_fwd
            assign out_d[i] = fwd_next[i] & irq_in[i];
        end else begin : g_idle
            assign out_d[i] = 1'b0;
            assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_out[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q;
endmodule

// File: rtl/sic_fwd_top.sv
module sic_fwd_top
    import sic_pkg::*;
#(
    parameter int unsigned FWD_LO   = 21,
    parameter int unsigned FWD_HI   = 30,
    parameter int unsigned SUM_LINE = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_in,
    input  logic [9:0]  bus_word,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] irq_out
);
    vec_t en_next, fwd_next, en_q, fwd_q, raw_q;

    sic_regbank #(.FWD_LO(FWD_LO), .FWD_HI(FWD_HI)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .word_idx (bus_word),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .en_next  (en_next),
        .fwd_next (fwd_next),
        .en_q     (en_q),
        .fwd_q    (fwd_q),
        .raw_q    (raw_q),
        .rdata    (bus_rdata)
    );

    sic_outstage #(.FWD_LO(FWD_LO), .FWD_HI(FWD_HI), .SUM_LINE(SUM_LINE)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .en_next  (en_next),
        .fwd_next (fwd_next),
        .irq_out  (irq_out)
    );

    assert_summary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[SUM_LINE] == |(raw_q & en_q));

    for (genvar i = FWD_LO; i <= FWD_HI; i++) begin : g_fwd_chk
        assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[i] == (fwd_q[i] & raw_q[i]));
    end

    assert_reset_R8: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_out == '0 && en_q == '0 && fwd_q == '0));
endmodule

// File: tb/sic_fwd_top_test.sv
module sic_fwd_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [9:0]  bus_word = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_en = '0;
    logic [31:0] m_fwd = '0;
    logic [31:0] rd_val;

    always #10 clk = ~clk;

    sic_fwd_top uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_word(bus_word),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_out(logic [31:0] in, logic [31:0] en, logic [31:0] fw);
        logic [31:0] r;
        r = in & fw & 32'h7FE0_0000;
        r[31] = |(in & en);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [9:0] idx, logic [31:0] in);
        case (idx)
            10'd0: return in & m_en;
            10'd1: return in;
            10'd2: return m_en;
            10'd4: return {31'd0, in[0]};
            10'd8: return m_fwd;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [9:0] idx, logic [31:0] d);
        case (idx)
            10'd2: m_en = m_en | d;
            10'd3: m_en = m_en & ~d;
            10'd4: if (d != 0) m_en[0] = 1'b1;
            10'd5: if (d != 0) m_en[0] = 1'b0;
            10'd8: m_fwd = m_fwd | (d & 32'h7FE0_0000);
            10'd9: m_fwd = m_fwd & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_write(logic [9:0] idx, logic [31:0] d);
        @(negedge clk);
        bus_word = idx; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(idx, d);
    endtask

    task automatic bus_read(logic [9:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_word = idx; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic set_in(logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 outputs", irq_out, 32'd0);
        chk("R8 rdata", bus_rdata, 32'd0);
        bus_read(10'd2, rd_val); chk("R8 enable", rd_val, 32'd0);
        bus_read(10'd8, rd_val); chk("R8 forward", rd_val, 32'd0);

        // R1 summary with and without enable
        set_in(32'h0000_0010);
        chk("R1 masked off", irq_out, 32'd0);
        bus_write(10'd2, 32'h0000_0010);
        chk("R1 enable raises summary", irq_out, 32'h8000_0000);
        set_in(32'h0);
        chk("R1 input drop", irq_out, 32'd0);

        // R3 set / clear selectivity
        bus_write(10'd2, 32'hF000_000F);
        bus_write(10'd3, 32'h1000_0001);
        bus_read(10'd2, rd_val); chk("R3 set/clear", rd_val, 32'hE000_001E);

        // R4 soft interrupt
        set_in(32'h0000_0001);
        bus_read(10'd4, rd_val); chk("R4 soft read", rd_val, 32'd1);
        bus_write(10'd4, 32'h0);
        chk("R4 zero write no effect", irq_out, 32'd0);
        bus_write(10'd4, 32'h8000_0000);
        chk("R4 soft set", irq_out, 32'h8000_0000);
        bus_write(10'd5, 32'h0);
        chk("R4 zero clear no effect", irq_out, 32'h8000_0000);
        bus_write(10'd5, 32'h4);
        chk("R4 soft clear", irq_out, 32'd0);

        // R5/R6 forwarding on a line already high
        set_in(32'hFFFF_FFFF);
        bus_write(10'd3, 32'hFFFF_FFFF);
        chk("R6 no forwarding", irq_out, 32'd0);
        bus_write(10'd8, 32'hFFFF_FFFF);
        chk("R6 forward on write", irq_out, 32'h7FE0_0000);
        bus_read(10'd8, rd_val); chk("R5 set mask", rd_val, 32'h7FE0_0000);
        bus_write(10'd9, 32'h0020_0000);
        chk("R6 clear line 21", irq_out, 32'h7FC0_0000);
        set_in(32'h4000_0000);
        chk("R6 follows input", irq_out, 32'h4000_0000);

        // R7 unmapped
        bus_write(10'd6, 32'hFFFF_FFFF);
        bus_write(10'd10, 32'hFFFF_FFFF);
        bus_write(10'd1023, 32'hFFFF_FFFF);
        bus_read(10'd2, rd_val); chk("R7 enable untouched", rd_val, m_en);
        bus_read(10'd8, rd_val); chk("R7 forward untouched", rd_val, m_fwd);
        bus_read(10'd7, rd_val); chk("R7 read zero", rd_val, 32'd0);

        // R9 idle read data
        @(negedge clk);
        chk("R9 idle rdata", bus_rdata, 32'd0);

        // Random mix: R1 R2 R5 R6 R7
        for (int k = 0; k < 400; k++) begin
            logic [9:0] idx;
            logic [31:0] d;
            idx = ($urandom % 8 == 0) ? 10'($urandom) : 10'($urandom % 12);
            d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            if ($urandom % 2 == 0) set_in($urandom);
            bus_write(idx, d);
            chk("R1/R6 random outputs", irq_out, exp_out(irq_in, m_en, m_fwd));
            idx = ($urandom % 6 == 0) ? 10'($urandom) : 10'($urandom % 12);
            bus_read(idx, rd_val);
            chk("R2/R7 random read", rd_val, exp_read(idx, irq_in));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule